// File: doc/BRIEF.md
# Burst Threshold Selection Counter

This block picks one of four burst-mode threshold settings for a switching power controller. It makes the choice once, during the first power-up. An external RC network is turned into a relaxation oscillator: the pin charges toward an upper level, and a discharge switch pulls it back down to a lower level. The block counts how many discharge cycles fit into a fixed timed window. A large capacitor charges slowly and gives few counts. A small capacitor gives many.

When the window closes, the count is decoded into a 2-bit level code. The code chooses the burst entry and exit thresholds, given as percent of maximum input power. Code 0 is 10%/20%. Code 1 is 6.67%/13.3%. Code 2 is 4.38%/9.6%. Code 3 means burst is never entered and always left. The window opens only when three conditions hold together: the supply is ready, the first-startup flag is high, and no protection is active. After the measurement the result is held until a full reset, so later restarts keep it.

The two comparator flags arrive from the analog side. Each passes through a two-flop synchronizer, and only its rising edges are acted on.

Top module: `burst_level_select`

## Requirements
- R1: After reset, `level` is 0 (the 10%/20% setting), `done` is 0 and `dis_en` is 0.
- R2: The window opens on the first clock edge at which `supply_ok`, `first_start` and not `prot_active` hold together. `done` rises WIN+1 rising clock edges after these inputs are applied.
- R3: While `prot_active` is high, no window opens. It opens once `prot_active` clears.
- R4: With `first_start` low (a restart), no window opens, and `level` and `done` keep their values.
- R5: During the window, a rising edge of `cmp_hi` with the discharge flag clear sets the flag and adds one to the count. `dis_en` goes high on the third rising clock edge after `cmp_hi` rises.
- R6: A rising edge of `cmp_lo` clears the discharge flag, so `dis_en` goes low on the third rising clock edge after `cmp_lo` rises.
- R7: A rising edge of `cmp_hi` while the discharge flag is already set is not counted.
- R8: At the close of the window, the count n gives the code as follows: n < B1 gives 0, B1 ≤ n < B2 gives 1, B2 ≤ n < B3 gives 2, and n ≥ B3 gives 3. The defaults are B1=4, B2=8 and B3=12.
- R9: Once `done` is high it stays high until reset. After that point `level` does not change, and comparator activity leaves `dis_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply has reached its turn-on level |
| first_start | input | 1 | This is the first startup since power was applied |
| prot_active | input | 1 | A protection condition is active |
| cmp_hi | input | 1 | Pin is at or above the upper level (asynchronous) |
| cmp_lo | input | 1 | Pin is at or below the lower level (asynchronous) |
| dis_en | output | 1 | Discharge switch enable |
| done | output | 1 | Measurement complete, sticky |
| level | output | 2 | Selected threshold code |

## Verification
Each comparator edge reaches `dis_en` three rising edges after it is driven: two synchronizer flops, then the discharge flag. The bench drives on falling edges and samples `dis_en` on the third falling edge that follows. `done` and `level` appear WIN+1 edges after the start conditions are applied. That edge is checked directly: `done` is low on the edge before it and high on that edge. For every measurement the driver queues the code it expects. A monitor waits for `done` to rise, then compares `level` on the next falling edge, so the comparison never races the register update.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    LVL_P10  = 2'd0,
    LVL_P667 = 2'd1,
    LVL_P438 = 2'd2,
    LVL_OFF  = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MEAS = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/bls_sync.sv
module bls_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= d_async[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise[i] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/bls_relax.sv
module bls_relax #(
  parameter int SAT   = 12,
  localparam int CW   = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          hi_rise,
  input  logic          lo_rise,
  output logic          dis_q,
  output logic [CW-1:0] count_q
);
  logic          dis_d;
  logic [CW-1:0] count_d;
  logic          count_en;

  always_comb begin
    dis_d    = dis_q;
    count_en = 1'b0;
    if (!active) begin
      dis_d = 1'b0;
    end else if (hi_rise && !dis_q) begin
      dis_d    = 1'b1;
      count_en = (count_q != CW'(SAT));
    end else if (lo_rise) begin
      dis_d = 1'b0;
    end
    count_d = count_en ? count_q + CW'(1) : count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q   <= 1'b0;
      count_q <= '0;
    end else begin
      dis_q <= dis_d;
      if (count_en) count_q <= count_d;
    end
  end

  // R5: the count only ever steps up by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> (count_q == $past(count_q) + CW'(1)));
  // R7: a counted cycle always comes with the discharge flag rising
  a_r7_count_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) |-> $rose(dis_q));
endmodule

// File: rtl/bls_window.sv
module bls_window
  import bls_pkg::*;
#(
  parameter int WIN = 256,
  parameter int B1  = 4,
  parameter int B2  = 8,
  parameter int B3  = 12,
  localparam int TW = $clog2(WIN),
  localparam int CW = $clog2(B3 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] count,
  output logic          meas,
  output logic          done,
  output lvl_e          level_q
);
  phase_e        ph_q, ph_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en, lvl_en, last;
  lvl_e          lvl_dec;

  assign last = (tmr_q == TW'(WIN - 1));

  always_comb begin
    if (count < CW'(B1))      lvl_dec = LVL_P10;
    else if (count < CW'(B2)) lvl_dec = LVL_P667;
    else if (count < CW'(B3)) lvl_dec = LVL_P438;
    else                      lvl_dec = LVL_OFF;
  end

  always_comb begin
    ph_d   = ph_q;
    tmr_en = 1'b0;
    lvl_en = 1'b0;
    tmr_d  = tmr_q + TW'(1);
    unique case (ph_q)
      PH_IDLE: if (go) ph_d = PH_MEAS;
      PH_MEAS: begin
        tmr_en = 1'b1;
        if (last) begin
          ph_d   = PH_DONE;
          lvl_en = 1'b1;
        end
      end
      default: ph_d = PH_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      tmr_q   <= '0;
      level_q <= LVL_P10;
    end else begin
      ph_q <= ph_d;
      if (tmr_en) tmr_q   <= tmr_d;
      if (lvl_en) level_q <= lvl_dec;
    end
  end

  assign meas = (ph_q == PH_MEAS);
  assign done = (ph_q == PH_DONE);

  // R9: completion is sticky
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> done);
  // R9: level frozen once done
  a_r9_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && done) |-> $stable(level_q));
  // R2: timer never exceeds the window
  a_r2_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= TW'(WIN - 1));
endmodule

// File: rtl/burst_level_select.sv
module burst_level_select
  import bls_pkg::*;
#(
  parameter int WIN = 256,
  parameter int B1  = 4,
  parameter int B2  = 8,
  parameter int B3  = 12,
  localparam int CW = $clog2(B3 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       first_start,
  input  logic       prot_active,
  input  logic       cmp_hi,
  input  logic       cmp_lo,
  output logic       dis_en,
  output logic       done,
  output logic [1:0] level
);
  logic          rs1_q, rs2_q;
  logic [1:0]    rise;
  logic          meas, go;
  logic [CW-1:0] count;
  lvl_e          lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign go = supply_ok & first_start & ~prot_active;

  bls_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rs2_q),
    .d_async ({cmp_lo, cmp_hi}),
    .rise    (rise)
  );

  bls_relax #(.SAT(B3)) u_relax (
    .clk     (clk),
    .rst_n   (rs2_q),
    .active  (meas),
    .hi_rise (rise[0]),
    .lo_rise (rise[1]),
    .dis_q   (dis_en),
    .count_q (count)
  );

  bls_window #(.WIN(WIN), .B1(B1), .B2(B2), .B3(B3)) u_win (
    .clk     (clk),
    .rst_n   (rs2_q),
    .go      (go),
    .count   (count),
    .meas    (meas),
    .done    (done),
    .level_q (lvl)
  );

  assign level = lvl;

  // R9: no discharge after completion
  a_r9_no_discharge_done: assert property (@(posedge clk) disable iff (!rs2_q)
    done |-> !dis_en);
  // R3: protection keeps the window shut
  a_r3_prot_holds: assert property (@(posedge clk) disable iff (!rs2_q)
    ($past(prot_active) && !$past(meas) && !$past(done)) |-> !meas);
  // R4: no window without the first-startup flag
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rs2_q)
    (!$past(first_start) && !$past(meas)) |-> !meas);
endmodule

// File: tb/tb_burst_level_select.sv
module tb_burst_level_select;
  localparam int WIN = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, first_start, prot_active, cmp_hi, cmp_lo;
  logic dis_en, done;
  logic [1:0] level;

  int total = 0;
  int bad   = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  burst_level_select dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .first_start(first_start),
    .prot_active(prot_active), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .dis_en(dis_en), .done(done), .level(level)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    supply_ok = 0; first_start = 0; prot_active = 0; cmp_hi = 0; cmp_lo = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
  endtask

  // one relaxation cycle; dbl adds an uncounted second upper edge
  task automatic pulse(bit dbl, bit chk);
    cmp_hi = 1; cyc(3);
    if (chk) check("R5 dis_en set", 8'(dis_en), 8'd1);
    cmp_hi = 0; cyc(2);
    if (dbl) begin
      cmp_hi = 1; cyc(3); cmp_hi = 0; cyc(2);
    end
    cmp_lo = 1; cyc(3);
    if (chk) check("R6 dis_en clear", 8'(dis_en), 8'd0);
    cmp_lo = 0; cyc(2);
  endtask

  // driver: push expected code, run measurement, wait for completion
  task automatic run_case(int n, bit dbl, logic [1:0] exp, string tag);
    do_reset();
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    supply_ok = 1; first_start = 1;
    cyc(1);
    for (int i = 0; i < n; i++) pulse(dbl, i == 0);
    wait (done);
    cyc(3);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge done);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check("R8 unexpected done", 8'(done), 8'd0);
      end else begin
        string t;
        logic [1:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 8'(level), 8'(e));
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0;
    supply_ok = 0; first_start = 0; prot_active = 0; cmp_hi = 0; cmp_lo = 0;
    do_reset();
    // R1
    check("R1 level", 8'(level), 8'd0);
    check("R1 done", 8'(done), 8'd0);
    check("R1 dis_en", 8'(dis_en), 8'd0);

    // R2 window length
    exp_q.push_back(2'd0); tag_q.push_back("R2 R8 zero count");
    supply_ok = 1; first_start = 1;
    cyc(WIN);
    check("R2 done before end", 8'(done), 8'd0);
    cyc(1);
    check("R2 done at end", 8'(done), 8'd1);
    cyc(2);

    // R8 boundaries
    run_case(3,  0, 2'd0, "R8 count 3");
    run_case(4,  0, 2'd1, "R8 count 4");
    run_case(7,  0, 2'd1, "R8 count 7");
    run_case(8,  0, 2'd2, "R8 count 8");
    run_case(11, 0, 2'd2, "R8 count 11");
    run_case(12, 0, 2'd3, "R8 count 12");
    // R9 after done: comparator activity ignored, level held
    pulse(0, 0);
    cmp_hi = 1; cyc(4);
    check("R9 dis_en after done", 8'(dis_en), 8'd0);
    check("R9 level held", 8'(level), 8'd3);
    check("R9 done sticky", 8'(done), 8'd1);
    cmp_hi = 0; cyc(2);
    // R7 double upper edges count once
    run_case(3, 1, 2'd0, "R7 double edges");

    // R3 protection hold-off
    do_reset();
    prot_active = 1; supply_ok = 1; first_start = 1;
    cyc(WIN + 10);
    check("R3 held by prot", 8'(done), 8'd0);
    exp_q.push_back(2'd0); tag_q.push_back("R3 after prot clear");
    prot_active = 0;
    cyc(WIN + 1);
    check("R3 runs after clear", 8'(done), 8'd1);
    cyc(2);

    // R4 restart: no detection
    do_reset();
    supply_ok = 1; first_start = 0;
    cmp_hi = 1; cyc(4);
    check("R4 no discharge", 8'(dis_en), 8'd0);
    cmp_hi = 0;
    cyc(WIN + 10);
    check("R4 no done", 8'(done), 8'd0);
    check("R4 level kept", 8'(level), 8'd0);

    check("R8 queue drained", 8'(exp_q.size()), 8'd0);
    finish_run();
  end
endmodule